// File: doc/BRIEF.md
# Multiplexed Row/Column Byte Memory Port

This block is a byte-wide parallel access port in front of a 512K x 8 storage array. The 19-bit array address never appears whole at the port. A shared address input carries it in two pieces of unequal width. An 8-bit row piece is captured when the row strobe is high. An 11-bit column piece is captured when the column strobe is high. The two captured pieces are merged into the full address, and that address is presented to the storage back end at all times.

Two active-low controls pick the operation. With output enable low and write enable high, the byte at the merged address is driven onto the data bus. With write enable low and output enable high, the port captures the data bus value. It commits that byte to storage once, when write enable returns high. Both controls low blocks writing. Both controls high leaves the port in standby. The data bus is modelled as a value plus a drive enable. A low synchronous reset halts the port and floats the bus. After reset is released, the port resumes read or standby according to the controls.

Top module: `mux_addr_port`

## Requirements
- R1: On a rising clock edge with `row_stb` high, `addr_in[7:0]` is stored as the row piece and appears on `mem_addr[18:11]` after that edge.
- R2: On a rising clock edge with `col_stb` high, `addr_in[10:0]` is stored as the column piece and appears on `mem_addr[10:0]` after that edge. Each piece holds its value while its strobe is low.
- R3: A clock edge that samples `oe_n`=0 and `we_n`=1 (read) sets `dq_oe`=1 and `dq_out` to the byte `mem_rdata` returns for `mem_addr`, both visible after that edge.
- R4: A clock edge that samples `oe_n`=1 leaves `dq_oe`=0 after that edge.
- R5: After one or more edges that sample `we_n`=0 with `oe_n`=1 (write), the first edge that samples `we_n`=1 raises `mem_we` for exactly the following cycle. During that cycle `mem_wdata` equals the `dq_in` value sampled at the last write edge, and `mem_addr` equals the merged address.
- R6: While `we_n` is held low, `mem_we` stays 0. Each low pulse of `we_n` produces at most one `mem_we` cycle.
- R7: A clock edge that samples `oe_n`=0 and `we_n`=0 (inhibit) gives no bus drive after it. A `we_n` pulse whose last low edge was an inhibit edge commits nothing.
- R8: A clock edge that samples `rst_n`=0 clears both address pieces to 0 and forces `dq_oe`=0 and `mem_we`=0. It also discards any pending write. After release, the port reads or stays in standby according to `oe_n` and `we_n`.
- R9: An edge that samples `oe_n`=1 and `we_n`=1 (standby) gives neither bus drive nor a write strobe, unless it completes a write pulse under R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset and halt |
| addr_in | input | 11 | Shared address input for the row and column pieces |
| row_stb | input | 1 | Capture the row piece this edge |
| col_stb | input | 1 | Capture the column piece this edge |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| dq_in | input | 8 | Data bus value seen by the port |
| dq_out | output | 8 | Data bus value driven by the port |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| mem_addr | output | 19 | Merged address to storage |
| mem_we | output | 1 | One-cycle commit strobe to storage |
| mem_wdata | output | 8 | Byte to commit |
| mem_rdata | input | 8 | Byte read from storage at `mem_addr` |

## Verification
The address patterns use all-zero pieces, all-one pieces, and alternating bit patterns in each piece. A single-bit row and a single-bit column show whether the split falls at bit 11 and whether the pieces are swapped or overlap. The read data model mixes row and column bits, so a read from a wrong address shows up. Write pulses of one and of several cycles tell a single commit on the release of write enable apart from a commit at every low cycle. Inhibit pulses, standby gaps and a reset in the middle of a read and of a write check that the bus floats and that pending writes are dropped.

// File: rtl/mux_port_pkg.sv
// Shared types for the multiplexed row/column memory port.
// Assumes: nothing beyond a single clock domain.
package mux_port_pkg;

    // Operating condition decoded from the two active-low controls.
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2,
        MODE_INHIBIT = 2'd3
    } port_mode_e;

endpackage

// File: rtl/addr_assembler.sv
// Captures the row and column pieces of the address from a shared input
// and merges them, row on top, into the full storage address.
// Assumes: BUS_W is at least as wide as either piece; strobes are synchronous.
module addr_assembler #(
    parameter int ROW_W = 8,
    parameter int COL_W = 11,
    parameter int BUS_W = 11,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_in,
    input  logic              row_stb,
    input  logic              col_stb,
    output logic [ADDR_W-1:0] full_addr
);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Row piece register: loads on its strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_q <= '0;
        else if (row_stb) row_q <= bus_in[ROW_W-1:0];
    end

    // Column piece register: loads on its strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       col_q <= '0;
        else if (col_stb) col_q <= bus_in[COL_W-1:0];
    end

    // Merge: row piece supplies the upper bits, column piece the lower.
    assign full_addr = {row_q, col_q};

    // R1
    row_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_stb |=> full_addr[ADDR_W-1:COL_W] == $past(bus_in[ROW_W-1:0]));

    // R2
    col_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_stb |=> full_addr[COL_W-1:0] == $past(bus_in[COL_W-1:0]));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_stb && !col_stb) |=> $stable(full_addr));

endmodule

// File: rtl/mode_decoder.sv
// Decodes the active-low controls into an operating mode and produces a
// single-cycle commit when write enable is released after a write.
// Assumes: controls are synchronous to clk.
module mode_decoder
    import mux_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oe_n,
    input  logic       we_n,
    output port_mode_e mode,
    output logic       commit
);

    logic armed_q;
    logic commit_q;

    // Mode decode from the control pair.
    always_comb begin
        case ({oe_n, we_n})
            2'b01:   mode = MODE_READ;
            2'b10:   mode = MODE_WRITE;
            2'b00:   mode = MODE_INHIBIT;
            default: mode = MODE_STANDBY;
        endcase
    end

    // Remembers that the last sampled cycle was a valid write.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= (mode == MODE_WRITE);
    end

    // Commit pulse on release of write enable after an armed write.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= armed_q && we_n;
    end

    assign commit = commit_q;

    // R6
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6
    no_commit_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !commit);

endmodule

// File: rtl/data_path.sv
// Registers the read byte and its drive enable, and holds the write byte
// captured during a write cycle.
// Assumes: storage read data is combinational from the presented address.
module data_path
    import mux_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_mode_e        mode,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic [DATA_W-1:0] wr_byte
);

    logic              drive_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] wbyte_q;

    // Drive enable: only a read condition drives the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= (mode == MODE_READ);
    end

    // Output byte: refreshed from storage on each read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 out_q <= '0;
        else if (mode == MODE_READ) out_q <= rd_byte;
    end

    // Write byte: follows the bus while a write condition holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wbyte_q <= '0;
        else if (mode == MODE_WRITE) wbyte_q <= bus_in;
    end

    assign bus_out   = out_q;
    assign bus_drive = drive_q;
    assign wr_byte   = wbyte_q;

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ) |=> (bus_drive && bus_out == $past(rd_byte)));

    // R7
    inhibit_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INHIBIT) |=> !bus_drive);

endmodule

// File: rtl/mux_addr_port.sv
// Top of the multiplexed row/column memory port: assembles the address,
// decodes read/write/inhibit/standby and drives the byte bus and storage.
// Assumes: single clock; synchronous active-low reset doubles as halt.
module mux_addr_port
    import mux_port_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 11,
    parameter int DATA_W = 8,
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  addr_in,
    input  logic              row_stb,
    input  logic              col_stb,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    port_mode_e mode;

    addr_assembler #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BUS_W (BUS_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (addr_in),
        .row_stb   (row_stb),
        .col_stb   (col_stb),
        .full_addr (mem_addr)
    );

    mode_decoder u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .mode   (mode),
        .commit (mem_we)
    );

    data_path #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .bus_in    (dq_in),
        .rd_byte   (mem_rdata),
        .bus_out   (dq_out),
        .bus_drive (dq_oe),
        .wr_byte   (mem_wdata)
    );

    // R4
    oe_high_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dq_oe);

    // R8
    reset_halt_chk: assert property (@(posedge clk)
        !rst_n |=> (!dq_oe && !mem_we));

    // R9
    standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && we_n && !$past(mode == MODE_WRITE)) |=> (!dq_oe && !mem_we));

endmodule

// File: tb/mux_addr_port_bench.sv
`timescale 1ns/1ps
module mux_addr_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr_in = '0;
    logic        row_stb = 1'b0;
    logic        col_stb = 1'b0;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [18:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Storage model: a byte derived from every address bit.
    function automatic logic [7:0] pat(input logic [18:0] a);
        return a[7:0] ^ a[18:11] ^ {5'b0, a[10:8]} ^ 8'h5A;
    endfunction
    assign mem_rdata = pat(mem_addr);

    mux_addr_port u_mux_addr_port (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .row_stb(row_stb),
        .col_stb(col_stb), .oe_n(oe_n), .we_n(we_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_addr(input logic [7:0] row, input logic [10:0] col);
        addr_in = {3'b111, row}; row_stb = 1'b1; tick();
        row_stb = 1'b0; addr_in = col; col_stb = 1'b1; tick();
        col_stb = 1'b0; addr_in = 11'h7FF; tick();
        chk("R1 row piece", mem_addr[18:11], row);
        chk("R2 column piece", mem_addr[10:0], col);
    endtask

    task automatic do_read();
        oe_n = 1'b0; we_n = 1'b1; tick();
        chk("R3 drive", dq_oe, 1'b1);
        chk("R3 data", dq_out, pat(mem_addr));
        oe_n = 1'b1; tick();
        chk("R4 float", dq_oe, 1'b0);
    endtask

    task automatic do_write(input logic [7:0] d, input int low_cycles);
        logic [18:0] a;
        a = mem_addr;
        oe_n = 1'b1; we_n = 1'b0; dq_in = ~d;
        for (int k = 0; k < low_cycles; k++) begin
            if (k == low_cycles - 1) dq_in = d;
            tick();
            chk("R6 no commit while low", mem_we, 1'b0);
            chk("R4 float in write", dq_oe, 1'b0);
        end
        we_n = 1'b1; dq_in = 8'h00; tick();
        chk("R5 commit", mem_we, 1'b1);
        chk("R5 data", mem_wdata, d);
        chk("R5 address", mem_addr, a);
        tick();
        chk("R6 single commit", mem_we, 1'b0);
    endtask

    task automatic do_inhibit();
        oe_n = 1'b0; we_n = 1'b0; dq_in = 8'hC3; tick();
        chk("R7 no drive", dq_oe, 1'b0);
        chk("R7 no write", mem_we, 1'b0);
        tick();
        oe_n = 1'b1; we_n = 1'b1; tick();
        chk("R7 no commit on release", mem_we, 1'b0);
        chk("R9 standby float", dq_oe, 1'b0);
    endtask

    // row, column, op (0 read, 1 write, 2 inhibit), data
    localparam logic [28:0] VEC [0:7] = '{
        {8'h00, 11'h000, 2'd0, 8'h00},
        {8'hFF, 11'h7FF, 2'd0, 8'h00},
        {8'h01, 11'h000, 2'd0, 8'h00},
        {8'h00, 11'h400, 2'd0, 8'h00},
        {8'hAA, 11'h555, 2'd1, 8'hA5},
        {8'h55, 11'h2AA, 2'd1, 8'h3C},
        {8'h80, 11'h001, 2'd2, 8'h00},
        {8'h3C, 11'h1E7, 2'd1, 8'hFF}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        chk("R8 reset drive", dq_oe, 1'b0);
        chk("R8 reset strobe", mem_we, 1'b0);
        chk("R8 reset address", mem_addr, 19'h0);
        rst_n = 1'b1; tick();
        chk("R9 standby idle", {dq_oe, mem_we}, 2'b00);

        for (int i = 0; i < 8; i++) begin
            logic [28:0] v;
            v = VEC[i];
            load_addr(v[28:21], v[20:10]);
            case (v[9:8])
                2'd0:    do_read();
                2'd1:    do_write(v[7:0], 1 + (i % 3));
                default: do_inhibit();
            endcase
        end

        // R2: address holds with strobes low while the input moves
        load_addr(8'h12, 11'h345);
        addr_in = 11'h0F0; tick(); tick();
        chk("R2 hold", mem_addr, {8'h12, 11'h345});

        // R6: long write pulse commits once
        do_write(8'h81, 6);

        // R8: reset in the middle of a read, then release into read
        oe_n = 1'b0; we_n = 1'b1; tick();
        chk("R3 before reset", dq_oe, 1'b1);
        rst_n = 1'b0; tick();
        chk("R8 halt float", dq_oe, 1'b0);
        chk("R8 address cleared", mem_addr, 19'h0);
        rst_n = 1'b1; tick();
        chk("R8 resume read", dq_oe, 1'b1);
        chk("R8 resume data", dq_out, pat(19'h0));
        oe_n = 1'b1; tick();

        // R8: reset during a write pulse discards it
        we_n = 1'b0; dq_in = 8'h77; tick();
        rst_n = 1'b0; tick();
        rst_n = 1'b1; we_n = 1'b1; tick();
        chk("R8 dropped write", mem_we, 1'b0);
        tick();
        chk("R8 dropped write later", mem_we, 1'b0);

        // R9: standby over several cycles
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R9 standby", {dq_oe, mem_we}, 2'b00);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule